// File: doc/BRIEF.md
# Signed-Digit Modular Adder-Subtractor

This block adds or subtracts two operands modulo a prime-field modulus. It is purely combinational. All three values are carried in a redundant signed-digit form. Each digit position has two wires, a positive bit and a negative bit, and the digit's value is the positive bit minus the negative bit. Because of this redundancy, every addition inside the block is carry-free. A change at one digit position affects the result only at that position and the one above it. The delay therefore does not grow with the operand width.

The block works in three passes.

1. **Raw sum or difference.** The first pass forms the raw sum, or the difference. Subtraction is done by swapping the positive and negative wires of the subtrahend and reusing the same adder.
2. **First correction.** The second pass looks at the top digit of that raw result. It subtracts the modulus when that digit is +1, adds the modulus when it is -1, and passes the value through when it is zero.
3. **Second correction.** The third pass applies one more correction of the same kind. Its sign comes from the most significant non-zero digit above the low N positions of the second result.

The digits left above position N-1 are then folded into a single signed digit of weight 2^N. The result is congruent to the exact answer but is not fully reduced. It may be negative, and it may be at least as large as the modulus. A later stage, or the next operation, absorbs this.

Top module: `rsd_mod_addsub`

## Requirements
- R1: Digit i of every vector has weight 2^i and value (positive bit − negative bit). An input digit with both bits set counts as 0. No output digit ever has both bits set.
- R2: With `opSub` = 0, the value of the result is congruent to A + B modulo the value of M.
- R3: With `opSub` = 1, the value of the result is congruent to A − B modulo the value of M.
- R4: When the value of M lies in [2^(N-1), 2^N − 1], the result value lies strictly between −2^N and 2^N. This holds for every encoding of any N-digit A and B. The result has N+1 digits, with the top digit at weight 2^N.
- R5: The first correction is steered by digit N of the raw sum or difference. A value of +1 selects subtraction of M, −1 selects addition of M, and 0 selects no correction. At most one of the two actions is taken.
- R6: The second correction is steered by the most significant non-zero digit among positions N and N+1 of the first-corrected value. The rules are the same: +1 subtracts M, −1 adds M, and no non-zero digit means no correction. When A and B are both zero, the result is exactly zero.
- R7: Different encodings of the same operand values give results congruent to each other. This includes digits with both bits set.
- R8: With N = 8, A = 85, B = 59 and M = 127, subtraction yields a value congruent to 26 and addition a value congruent to 17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aPos | input | N | Positive bits of operand A |
| aNeg | input | N | Negative bits of operand A |
| bPos | input | N | Positive bits of operand B |
| bNeg | input | N | Negative bits of operand B |
| mPos | input | N | Positive bits of the modulus |
| mNeg | input | N | Negative bits of the modulus |
| opSub | input | 1 | 0 selects A + B, 1 selects A − B |
| rPos | output | N+1 | Positive bits of the result |
| rNeg | output | N+1 | Negative bits of the result |

## Verification
The bench builds the block with the default N = 8. This width makes the worked 85/59/127 cases reachable directly. It also lets moduli be swept across the whole admissible window from 128 to 255. Random operands with every digit drawn from {−1, 0, +1} exercise both correction stages in both directions. The all-plus and all-minus extremes against the smallest and largest moduli press the bound of R4 at its edges.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  // Steering strobes from the control to the datapath.
  typedef struct packed {
    logic negB;     // swap the wires of B (subtract)
    logic fix2Add;  // stage two adds M
    logic fix2Sub;  // stage two subtracts M
    logic fix3Add;  // stage three adds M
    logic fix3Sub;  // stage three subtracts M
  } rsdCtrl_t;

  // Value of one digit; both bits set reads as zero.
  function automatic logic signed [2:0] digitVal(input logic p, input logic n);
    if (p && !n)      return 3'sd1;
    else if (n && !p) return -3'sd1;
    else              return 3'sd0;
  endfunction

  // Integer value of a signed-digit vector of w digits (w <= 62).
  function automatic longint sdValue(input logic [63:0] p, input logic [63:0] n, input int w);
    longint acc;
    acc = 0;
    for (int i = 0; i < w; i++) begin
      if (p[i] && !n[i])      acc = acc + (longint'(1) <<< i);
      else if (n[i] && !p[i]) acc = acc - (longint'(1) <<< i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/rsd_sd_add.sv
// Carry-free signed-digit adder: W digits in, W+1 digits out.
module rsd_sd_add
  import rsd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] xPos,
  input  logic [W-1:0] xNeg,
  input  logic [W-1:0] yPos,
  input  logic [W-1:0] yNeg,
  output logic [W:0]   sPos,
  output logic [W:0]   sNeg
);

  logic [W-1:0] isNeg;
  logic [W-1:0] lowNeg;
  logic [W-1:0] trPos;
  logic [W-1:0] trNeg;

  assign isNeg  = (xNeg & ~xPos) | (yNeg & ~yPos);
  assign lowNeg = {isNeg[W-2:0], 1'b0};

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : gDig
      logic signed [2:0] pSum;
      logic signed [2:0] tr;
      logic signed [2:0] wv;
      logic signed [2:0] tIn;
      logic signed [2:0] sd;

      always_comb begin
        pSum = digitVal(xPos[i], xNeg[i]) + digitVal(yPos[i], yNeg[i]);
        case (pSum)
          3'sd2:  begin tr = 3'sd1;  wv = 3'sd0; end
          -3'sd2: begin tr = -3'sd1; wv = 3'sd0; end
          3'sd1:  begin
            if (lowNeg[i]) begin tr = 3'sd0; wv = 3'sd1;  end
            else           begin tr = 3'sd1; wv = -3'sd1; end
          end
          -3'sd1: begin
            if (lowNeg[i]) begin tr = -3'sd1; wv = 3'sd1;  end
            else           begin tr = 3'sd0;  wv = -3'sd1; end
          end
          default: begin tr = 3'sd0; wv = 3'sd0; end
        endcase
      end

      assign trPos[i] = (tr == 3'sd1);
      assign trNeg[i] = (tr == -3'sd1);

      if (i == 0) begin : gLsb
        assign tIn = 3'sd0;
      end else begin : gUp
        assign tIn = digitVal(trPos[i-1], trNeg[i-1]);
      end

      assign sd      = wv + tIn;
      assign sPos[i] = (sd == 3'sd1);
      assign sNeg[i] = (sd == -3'sd1);
    end
  endgenerate

  assign sPos[W] = trPos[W-1];
  assign sNeg[W] = trNeg[W-1];

endmodule

// File: rtl/rsd_mod_dp.sv
// Datapath: three cascaded carry-free stages plus the top-digit fold.
module rsd_mod_dp
  import rsd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] aPos,
  input  logic [N-1:0] aNeg,
  input  logic [N-1:0] bPos,
  input  logic [N-1:0] bNeg,
  input  logic [N-1:0] mPos,
  input  logic [N-1:0] mNeg,
  input  rsdCtrl_t     ctrl,
  output logic         t1TopPos,
  output logic         t1TopNeg,
  output logic [1:0]   t2HiPos,
  output logic [1:0]   t2HiNeg,
  output logic [N:0]   rPos,
  output logic [N:0]   rNeg
);

  localparam int W2 = N + 1;
  localparam int W3 = N + 2;

  logic [N-1:0]  ybPos, ybNeg;
  logic [N:0]    t1Pos, t1Neg;
  logic [W2-1:0] m2Pos, m2Neg;
  logic [W2:0]   t2Pos, t2Neg;
  logic [W3-1:0] m3Pos, m3Neg;
  logic [W3:0]   t3Pos, t3Neg;
  logic signed [4:0] foldVal;

  // Stage one: A plus B, or A plus negated B.
  assign ybPos = ctrl.negB ? bNeg : bPos;
  assign ybNeg = ctrl.negB ? bPos : bNeg;

  rsd_sd_add #(.W(N)) uStage1 (
    .xPos(aPos), .xNeg(aNeg), .yPos(ybPos), .yNeg(ybNeg),
    .sPos(t1Pos), .sNeg(t1Neg)
  );

  // Stage two: optional +/-M.
  always_comb begin
    m2Pos = '0;
    m2Neg = '0;
    if (ctrl.fix2Add) begin
      m2Pos = W2'(mPos);
      m2Neg = W2'(mNeg);
    end else if (ctrl.fix2Sub) begin
      m2Pos = W2'(mNeg);
      m2Neg = W2'(mPos);
    end
  end

  rsd_sd_add #(.W(W2)) uStage2 (
    .xPos(t1Pos), .xNeg(t1Neg), .yPos(m2Pos), .yNeg(m2Neg),
    .sPos(t2Pos), .sNeg(t2Neg)
  );

  // Stage three: optional +/-M.
  always_comb begin
    m3Pos = '0;
    m3Neg = '0;
    if (ctrl.fix3Add) begin
      m3Pos = W3'(mPos);
      m3Neg = W3'(mNeg);
    end else if (ctrl.fix3Sub) begin
      m3Pos = W3'(mNeg);
      m3Neg = W3'(mPos);
    end
  end

  rsd_sd_add #(.W(W3)) uStage3 (
    .xPos(t2Pos), .xNeg(t2Neg), .yPos(m3Pos), .yNeg(m3Neg),
    .sPos(t3Pos), .sNeg(t3Neg)
  );

  // Collapse digits N..N+2 into one digit of weight 2^N.
  always_comb begin
    foldVal = 5'(digitVal(t3Pos[N], t3Neg[N]))
            + 5'(digitVal(t3Pos[N+1], t3Neg[N+1])) * 5'sd2
            + 5'(digitVal(t3Pos[N+2], t3Neg[N+2])) * 5'sd4;
  end

  assign rPos = {foldVal == 5'sd1,  t3Pos[N-1:0]};
  assign rNeg = {foldVal == -5'sd1, t3Neg[N-1:0]};

  assign t1TopPos = t1Pos[N];
  assign t1TopNeg = t1Neg[N];
  assign t2HiPos  = t2Pos[N+1:N];
  assign t2HiNeg  = t2Neg[N+1:N];

endmodule

// File: rtl/rsd_mod_ctl.sv
// Control: turns the select and the top digits into steering strobes.
module rsd_mod_ctl
  import rsd_pkg::*;
(
  input  logic       opSub,
  input  logic       t1TopPos,
  input  logic       t1TopNeg,
  input  logic [1:0] t2HiPos,
  input  logic [1:0] t2HiNeg,
  output rsdCtrl_t   ctrl
);

  logic signed [2:0] d1, dHi, dLo, dSel;

  always_comb begin
    d1   = digitVal(t1TopPos, t1TopNeg);
    dHi  = digitVal(t2HiPos[1], t2HiNeg[1]);
    dLo  = digitVal(t2HiPos[0], t2HiNeg[0]);
    dSel = (dHi != 3'sd0) ? dHi : dLo;

    ctrl.negB    = opSub;
    ctrl.fix2Sub = (d1 == 3'sd1);
    ctrl.fix2Add = (d1 == -3'sd1);
    ctrl.fix3Sub = (dSel == 3'sd1);
    ctrl.fix3Add = (dSel == -3'sd1);
  end

endmodule

// File: rtl/rsd_mod_addsub.sv
// Thin top: control and datapath.
module rsd_mod_addsub
  import rsd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] aPos,
  input  logic [N-1:0] aNeg,
  input  logic [N-1:0] bPos,
  input  logic [N-1:0] bNeg,
  input  logic [N-1:0] mPos,
  input  logic [N-1:0] mNeg,
  input  logic         opSub,
  output logic [N:0]   rPos,
  output logic [N:0]   rNeg
);

  rsdCtrl_t   ctrl;
  logic       t1TopPos, t1TopNeg;
  logic [1:0] t2HiPos, t2HiNeg;

  rsd_mod_ctl uCtl (
    .opSub(opSub), .t1TopPos(t1TopPos), .t1TopNeg(t1TopNeg),
    .t2HiPos(t2HiPos), .t2HiNeg(t2HiNeg), .ctrl(ctrl)
  );

  rsd_mod_dp #(.N(N)) uDp (
    .aPos(aPos), .aNeg(aNeg), .bPos(bPos), .bNeg(bNeg),
    .mPos(mPos), .mNeg(mNeg), .ctrl(ctrl),
    .t1TopPos(t1TopPos), .t1TopNeg(t1TopNeg),
    .t2HiPos(t2HiPos), .t2HiNeg(t2HiNeg),
    .rPos(rPos), .rNeg(rNeg)
  );

endmodule

// File: rtl/rsd_mod_chk.sv
// Checker for rsd_mod_addsub, attached below with bind.
module rsd_mod_chk
  import rsd_pkg::*;
#(
  parameter int N = 8
) (
  input logic [N-1:0] aPos,
  input logic [N-1:0] aNeg,
  input logic [N-1:0] bPos,
  input logic [N-1:0] bNeg,
  input logic [N-1:0] mPos,
  input logic [N-1:0] mNeg,
  input logic         opSub,
  input logic [N:0]   rPos,
  input logic [N:0]   rNeg,
  input rsdCtrl_t     ctrl,
  input logic         t1TopPos,
  input logic         t1TopNeg,
  input logic [1:0]   t2HiPos,
  input logic [1:0]   t2HiNeg
);

  localparam longint MLO = longint'(1) <<< (N - 1);
  localparam longint MHI = (longint'(1) <<< N) - 1;

  longint aVal, bVal, mVal, rVal, diff;
  logic   mOk;

  always_comb begin
    aVal = sdValue(64'(aPos), 64'(aNeg), N);
    bVal = sdValue(64'(bPos), 64'(bNeg), N);
    mVal = sdValue(64'(mPos), 64'(mNeg), N);
    rVal = sdValue(64'(rPos), 64'(rNeg), N + 1);
    mOk  = (mVal >= MLO) && (mVal <= MHI);
    diff = opSub ? (rVal - (aVal - bVal)) : (rVal - (aVal + bVal));

    assert_digit_canon_R1: assert ((rPos & rNeg) == '0)
      else $error("R1: output digit with both bits set");

    if (mOk && !opSub) begin
      assert_add_congr_R2: assert ((diff % mVal) == 0)
        else $error("R2: sum not congruent");
    end
    if (mOk && opSub) begin
      assert_sub_congr_R3: assert ((diff % mVal) == 0)
        else $error("R3: difference not congruent");
    end
    if (mOk) begin
      assert_bound_R4: assert (rVal > -(MHI + 1) && rVal < (MHI + 1))
        else $error("R4: result out of bound");
    end

    assert_fix2_onehot_R5: assert ($onehot0({ctrl.fix2Add, ctrl.fix2Sub}))
      else $error("R5: both stage-two strobes");
    assert_fix2_sign_R5: assert ((ctrl.fix2Sub == (t1TopPos && !t1TopNeg))
                                 && (ctrl.fix2Add == (t1TopNeg && !t1TopPos)))
      else $error("R5: stage-two steering");

    assert_fix3_onehot_R6: assert ($onehot0({ctrl.fix3Add, ctrl.fix3Sub}))
      else $error("R6: both stage-three strobes");
    assert_fix3_idle_R6: assert ((((t2HiPos ^ t2HiNeg) == 2'b00))
                                 -> !(ctrl.fix3Add || ctrl.fix3Sub))
      else $error("R6: correction without a top digit");
  end

endmodule

bind rsd_mod_addsub rsd_mod_chk #(.N(N)) uChk (
  .aPos(aPos), .aNeg(aNeg), .bPos(bPos), .bNeg(bNeg),
  .mPos(mPos), .mNeg(mNeg), .opSub(opSub),
  .rPos(rPos), .rNeg(rNeg), .ctrl(ctrl),
  .t1TopPos(t1TopPos), .t1TopNeg(t1TopNeg),
  .t2HiPos(t2HiPos), .t2HiNeg(t2HiNeg)
);

// File: tb/sim_rsd_mod_addsub.sv
module sim_rsd_mod_addsub;

  localparam int N = 8;
  localparam longint MLO = longint'(1) <<< (N - 1);
  localparam longint LIM = longint'(1) <<< N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] aPos, aNeg, bPos, bNeg, mPos, mNeg;
  logic         opSub;
  logic [N:0]   rPos, rNeg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  rsd_mod_addsub #(.N(N)) u0 (
    .aPos(aPos), .aNeg(aNeg), .bPos(bPos), .bNeg(bNeg),
    .mPos(mPos), .mNeg(mNeg), .opSub(opSub),
    .rPos(rPos), .rNeg(rNeg)
  );

  function automatic longint val(input logic [63:0] p, input logic [63:0] n, input int w);
    longint acc = 0;
    for (int i = 0; i < w; i++) begin
      if (p[i] && !n[i])      acc += (longint'(1) <<< i);
      else if (n[i] && !p[i]) acc -= (longint'(1) <<< i);
    end
    return acc;
  endfunction

  function automatic longint modp(input longint x, input longint m);
    longint r = x % m;
    return (r < 0) ? r + m : r;
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] ap, an, bp, bn, mp, mn, input logic sub);
    @(posedge clk);
    aPos = ap; aNeg = an; bPos = bp; bNeg = bn; mPos = mp; mNeg = mn; opSub = sub;
    @(negedge clk);
  endtask

  function automatic longint rv();
    return val(64'(rPos), 64'(rNeg), N + 1);
  endfunction

  // Congruence (R2/R3), bound (R4) and encoding (R1) for the applied vector.
  task automatic checkCommon(input string tag);
    longint a = val(64'(aPos), 64'(aNeg), N);
    longint b = val(64'(bPos), 64'(bNeg), N);
    longint m = val(64'(mPos), 64'(mNeg), N);
    longint exp = opSub ? modp(a - b, m) : modp(a + b, m);
    check(opSub ? {tag, " R3"} : {tag, " R2"}, modp(rv(), m) == exp, modp(rv(), m), exp);
    check({tag, " R4"}, (rv() > -LIM) && (rv() < LIM), rv(), 0);
    check({tag, " R1"}, (rPos & rNeg) == '0, longint'(rPos & rNeg), 0);
  endtask

  function automatic void randDigits(output logic [N-1:0] p, output logic [N-1:0] n);
    for (int i = 0; i < N; i++) begin
      case ($urandom % 3)
        0:       begin p[i] = 1'b0; n[i] = 1'b0; end
        1:       begin p[i] = 1'b1; n[i] = 1'b0; end
        default: begin p[i] = 1'b0; n[i] = 1'b1; end
      endcase
    end
  endfunction

  task automatic tZero();
    drive('0, '0, '0, '0, N'(127), '0, 1'b0);
    check("zero add R6", rv() == 0, rv(), 0);
    drive('0, '0, '0, '0, N'(200), '0, 1'b1);
    check("zero sub R6 R5", rv() == 0, rv(), 0);
  endtask

  task automatic tExamples();
    drive(N'(85), '0, N'(59), '0, N'(127), '0, 1'b1);
    check("85-59 R8", modp(rv(), 127) == 26, modp(rv(), 127), 26);
    checkCommon("ex-sub");
    drive(N'(85), '0, N'(59), '0, N'(127), '0, 1'b0);
    check("85+59 R8", modp(rv(), 127) == 17, modp(rv(), 127), 17);
    checkCommon("ex-add");
  endtask

  task automatic tRandom(input logic sub, input int count);
    logic [N-1:0] ap, an, bp, bn;
    for (int k = 0; k < count; k++) begin
      randDigits(ap, an);
      randDigits(bp, bn);
      drive(ap, an, bp, bn, N'($urandom_range(int'(LIM - 1), int'(MLO))), '0, sub);
      checkCommon(sub ? "rand-sub" : "rand-add");
    end
  endtask

  task automatic tExtremes();
    logic [N-1:0] ones = '1;
    for (int s = 0; s < 2; s++) begin
      drive(ones, '0, '0, ones, N'(MLO), '0, logic'(s));
      checkCommon("ext-a R4");
      drive('0, ones, ones, '0, N'(MLO), '0, logic'(s));
      checkCommon("ext-b R4");
      drive(ones, '0, ones, '0, ones, '0, logic'(s));
      checkCommon("ext-c R4");
      drive('0, ones, '0, ones, ones, '0, logic'(s));
      checkCommon("ext-d R4");
    end
  endtask

  // Both-bits-set digits read as zero; alternate encodings agree (R1, R7).
  task automatic tEncodings();
    logic [N-1:0] ones = '1;
    longint r0;
    drive(ones, ones, N'(59), '0, N'(127), '0, 1'b0);
    check("both-set A R7", modp(rv(), 127) == 59, modp(rv(), 127), 59);
    drive(N'(85), '0, ones, ones, N'(127), '0, 1'b1);
    check("both-set B R7", modp(rv(), 127) == 85, modp(rv(), 127), 85);
    drive(N'(85), '0, N'(59), '0, N'(131), '0, 1'b1);
    r0 = modp(rv(), 131);
    // 85 = 128 - 43 as +1 at bit7, -1 at bits 5,3,1,0
    drive(N'(8'b1000_0000), N'(8'b0010_1011), N'(59), '0, N'(131), '0, 1'b1);
    check("alt-enc R7", modp(rv(), 131) == r0, modp(rv(), 131), r0);
    // 131 as 2^8 - 125 is not N-digit; use 131 = 128+4-1
    drive(N'(85), '0, N'(59), '0, N'(8'b1000_0100), N'(8'b0000_0001), 1'b1);
    check("alt-mod R7", modp(rv(), 131) == r0, modp(rv(), 131), r0);
  endtask

  initial begin
    aPos = '0; aNeg = '0; bPos = '0; bNeg = '0; mPos = N'(127); mNeg = '0; opSub = 1'b0;
    @(negedge clk);
    check("reset-state R1", (rPos & rNeg) == '0 && rv() == 0, rv(), 0);
    tZero();
    tExamples();
    tEncodings();
    tExtremes();
    tRandom(1'b0, 300);
    tRandom(1'b1, 300);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule